// File: doc/BRIEF.md
# Serial Port Status and Interrupt Unit

This block turns the fill levels of a serial port's transmit and receive FIFOs into a status word and a set of interrupt sources. It also holds the interrupt mask and drives one combined interrupt line. Each FIFO is 8 words deep by default. The block receives both FIFO counts, two single-cycle event pulses (receive overrun and receive timeout), and write strobes for the mask and for the interrupt clear. It does not contain FIFO storage or any bus decoding.

Two kinds of interrupt source exist. The receive and transmit sources are levels: they follow the FIFO counts around the half-full mark every cycle, and software cannot clear them. Overrun and timeout are sticky: a pulse sets them, and they stay set until a write-1-to-clear removes them. Every output is registered, so each one reflects the inputs that were present at the previous rising clock edge.

Top module: `ssp_irq_unit`

## Requirements
- R1: Status bit positions are: bit 0 is set when the transmit count is 0; bit 1 is set when the transmit count is not equal to the depth (8); bit 2 is set when the receive count is not 0; bit 3 is set when the receive count equals the depth; bit 4 (busy) is set when the transmit count is not 0.
- R2: Raw interrupt bit 2 (receive level) is 1 whenever the receive count is 4 or more, and 0 otherwise. It is not latched.
- R3: Raw interrupt bit 3 (transmit level) is 1 whenever the transmit count is 4 or less, and 0 otherwise. It is not latched.
- R4: Raw bit 0 (overrun) is set by a one-cycle overrun pulse, and raw bit 1 (timeout) is set by a one-cycle timeout pulse. Each bit stays set on idle cycles until it is cleared.
- R5: A clear write with data bit 0 or bit 1 set clears the matching sticky raw bit. Clear data bits 2 and 3 have no effect on the raw word.
- R6: If an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: A mask write loads the 4-bit mask. The masked word equals the raw word ANDed with the mask.
- R8: The interrupt line is 1 exactly when the masked word is nonzero.
- R9: Every output changes one clock after the input change that causes it. No output responds combinationally.
- R10: After reset: status = 5'b00011, raw = 4'b1000, masked = 0, irq = 0, mask = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_count | input | CNT_W (4) | Transmit FIFO fill level, 0..DEPTH |
| rx_count | input | CNT_W (4) | Receive FIFO fill level, 0..DEPTH |
| ovr_pulse | input | 1 | One-cycle receive overrun event |
| rto_pulse | input | 1 | One-cycle receive timeout event |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | Mask value |
| clr_we | input | 1 | Interrupt clear write strobe |
| clr_wdata | input | 4 | Write-1-to-clear bits |
| status | output | 5 | Registered FIFO status flags |
| raw_irq | output | 4 | Registered raw interrupt status |
| masked_irq | output | 4 | Registered raw AND mask |
| irq | output | 1 | Combined interrupt line |

## Verification
Every result (status, raw, masked and irq) is due exactly one rising edge after the stimulus that causes it. The bench drives inputs on the falling edge and samples on the following falling edge, which is one register stage later. One check instead samples before that edge, to confirm the old value is still held there. The two counts are swept over all 81 combinations, and the expected flags are computed from the counts. The mask is swept over all 16 values, and the sticky bits are traced through set, hold, clear and collision cycles.

// File: rtl/ssp_irq_pkg.sv
// Package: bit positions and widths shared by the status/interrupt unit.
// Assumes the consumers index status and interrupt words only through these names.
package ssp_irq_pkg;
    localparam int ST_W    = 5;
    localparam int IRQ_W   = 4;
    localparam int NSTICKY = 2;

    localparam int ST_TXE = 0;
    localparam int ST_TNF = 1;
    localparam int ST_RNE = 2;
    localparam int ST_RFF = 3;
    localparam int ST_BSY = 4;

    localparam int IRQ_OVR = 0;
    localparam int IRQ_RTO = 1;
    localparam int IRQ_RXL = 2;
    localparam int IRQ_TXL = 3;

    localparam logic [ST_W-1:0]  ST_RESET  = 5'b00011;
    localparam logic [IRQ_W-1:0] IRQ_RESET = 4'b1000;
endpackage

// File: rtl/ssp_sts_decode.sv
// Status decoder: registers the five FIFO status flags from the two counts.
// Assumes counts never exceed DEPTH; updates one clock after a count change.
module ssp_sts_decode
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic [ST_W-1:0]  status_q
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ST_W-1:0] status_nxt;

    // Decode each flag from the current counts.
    always_comb begin
        status_nxt         = '0;
        status_nxt[ST_TXE] = (tx_cnt == '0);
        status_nxt[ST_TNF] = (tx_cnt != FULL);
        status_nxt[ST_RNE] = (rx_cnt != '0);
        status_nxt[ST_RFF] = (rx_cnt == FULL);
        status_nxt[ST_BSY] = (tx_cnt != '0);
    end

    // Register the flags; reset shows an empty, not-full transmit side.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= ST_RESET;
        else        status_q <= status_nxt;
    end

    AST_BUSY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt != '0) |=> (status_q[ST_BSY] && !status_q[ST_TXE])); // R1
    AST_RX_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == FULL) |=> (status_q[ST_RFF] && status_q[ST_RNE])); // R1
endmodule

// File: rtl/ssp_irq_raw.sv
// Raw interrupt sources: two sticky event bits (write-1-to-clear, set wins)
// and two level bits that follow the FIFO counts at the half-full marks.
// Assumes event pulses last one cycle; exports the next-state word.
module ssp_irq_raw
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int RX_MARK = DEPTH / 2,
    parameter int TX_MARK = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             ovr_evt,
    input  logic             rto_evt,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_data,
    output logic [IRQ_W-1:0] raw_nxt,
    output logic [IRQ_W-1:0] raw_q
);
    localparam logic [CNT_W-1:0] RX_LVL = CNT_W'(RX_MARK);
    localparam logic [CNT_W-1:0] TX_LVL = CNT_W'(TX_MARK);

    logic [NSTICKY-1:0] evt;
    logic [NSTICKY-1:0] sticky_nxt;

    // Gather event pulses in bit order of the raw word.
    always_comb begin
        evt          = '0;
        evt[IRQ_OVR] = ovr_evt;
        evt[IRQ_RTO] = rto_evt;
    end

    for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
        // Next state of one sticky bit: event beats clear, else hold.
        always_comb begin
            if (evt[k])                      sticky_nxt[k] = 1'b1;
            else if (clr_we && clr_data[k])  sticky_nxt[k] = 1'b0;
            else                             sticky_nxt[k] = raw_q[k];
        end

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[k] && !(clr_we && clr_data[k])) |=> raw_q[k]); // R4
        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> raw_q[k]); // R6
        AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[k] && !evt[k]) |=> !raw_q[k]); // R5
    end

    // Assemble the full next raw word from sticky and level sources.
    always_comb begin
        raw_nxt                = '0;
        raw_nxt[NSTICKY-1:0]   = sticky_nxt;
        raw_nxt[IRQ_RXL]       = (rx_cnt >= RX_LVL);
        raw_nxt[IRQ_TXL]       = (tx_cnt <= TX_LVL);
    end

    // Register the raw word; reset leaves only the transmit level set.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= IRQ_RESET;
        else        raw_q <= raw_nxt;
    end

    AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= RX_LVL) |=> raw_q[IRQ_RXL]); // R2
    AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt > TX_LVL) |=> !raw_q[IRQ_TXL]); // R3
endmodule

// File: rtl/ssp_irq_mask.sv
// Mask stage: holds the mask, registers raw AND mask, and drives the line.
// Assumes raw_nxt is the value the raw register takes at the same edge.
module ssp_irq_mask
    import ssp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_data,
    input  logic [IRQ_W-1:0] raw_nxt,
    output logic [IRQ_W-1:0] mask_q,
    output logic [IRQ_W-1:0] masked_q,
    output logic             irq_q
);
    logic [IRQ_W-1:0] mask_nxt;
    logic [IRQ_W-1:0] masked_nxt;

    // Select the mask that will hold after this edge.
    always_comb begin
        mask_nxt   = mask_we ? mask_data : mask_q;
        masked_nxt = raw_nxt & mask_nxt;
    end

    // Register mask, masked word and combined line together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            masked_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            mask_q   <= mask_nxt;
            masked_q <= masked_nxt;
            irq_q    <= |masked_nxt;
        end
    end

    AST_MASK_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_data))); // R7
    AST_LINE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (masked_q != '0)); // R8
endmodule

// File: rtl/ssp_irq_unit.sv
// Top: FIFO status flags and interrupt sources for a serial port.
// Assumes counts within 0..DEPTH and single-cycle event pulses; all outputs
// are registered and lag their inputs by one clock.
module ssp_irq_unit
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             ovr_pulse,
    input  logic             rto_pulse,
    input  logic             mask_we,
    input  logic [3:0]       mask_wdata,
    input  logic             clr_we,
    input  logic [3:0]       clr_wdata,
    output logic [4:0]       status,
    output logic [3:0]       raw_irq,
    output logic [3:0]       masked_irq,
    output logic             irq
);
    localparam int HALF = DEPTH / 2;

    logic [IRQ_W-1:0] raw_nxt;
    logic [IRQ_W-1:0] mask_q;

    ssp_sts_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_cnt   (tx_count),
        .rx_cnt   (rx_count),
        .status_q (status)
    );

    ssp_irq_raw #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RX_MARK(HALF), .TX_MARK(HALF)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_cnt   (tx_count),
        .rx_cnt   (rx_count),
        .ovr_evt  (ovr_pulse),
        .rto_evt  (rto_pulse),
        .clr_we   (clr_we),
        .clr_data (clr_wdata),
        .raw_nxt  (raw_nxt),
        .raw_q    (raw_irq)
    );

    ssp_irq_mask u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_data (mask_wdata),
        .raw_nxt   (raw_nxt),
        .mask_q    (mask_q),
        .masked_q  (masked_irq),
        .irq_q     (irq)
    );

    AST_MASKED_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        masked_irq == (raw_irq & mask_q)); // R7
endmodule

// File: tb/tb_ssp_irq_unit.sv
module tb_ssp_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_count = '0, rx_count = '0;
    logic       ovr_pulse = 0, rto_pulse = 0, mask_we = 0, clr_we = 0;
    logic [3:0] mask_wdata = '0, clr_wdata = '0;
    logic [4:0] status;
    logic [3:0] raw_irq, masked_irq;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ssp_irq_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FIFO check FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [4:0] exp_status(input int t, input int r);
        exp_status = {t != 0, r == 8, r != 0, t != 8, t == 0};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] sticky;
        logic [3:0] raw_e;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk("R10 status", status, 5'b00011);
        chk("R10 raw", raw_irq, 4'b1000);
        chk("R10 masked", masked_irq, 4'b0000);
        chk("R10 irq", irq, 1'b0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3: exhaustive count sweep
        for (int t = 0; t <= 8; t++) begin
            for (int r = 0; r <= 8; r++) begin
                tx_count = 4'(t); rx_count = 4'(r);
                step();
                chk("R1 status", status, exp_status(t, r));
                chk("R2 rx level", raw_irq[2], r >= 4);
                chk("R3 tx level", raw_irq[3], t <= 4);
            end
        end

        // R9: one-clock latency, old value held before the edge
        tx_count = 4'd8; rx_count = 4'd0;
        step();
        tx_count = 4'd0;
        #1;
        chk("R9 before edge", status[0], 1'b0);
        step();
        chk("R9 after edge", status[0], 1'b1);

        // R4: overrun set and held
        tx_count = 4'd2; rx_count = 4'd6;   // levels: rx=1, tx=1
        ovr_pulse = 1; step(); ovr_pulse = 0;
        chk("R4 ovr set", raw_irq, 4'b1101);
        repeat (3) step();
        chk("R4 ovr held", raw_irq, 4'b1101);
        rto_pulse = 1; step(); rto_pulse = 0;
        chk("R4 rto set", raw_irq, 4'b1111);

        // R7 R8: mask sweep over all values
        for (int m = 0; m < 16; m++) begin
            mask_we = 1; mask_wdata = 4'(m); step(); mask_we = 0;
            chk("R7 masked", masked_irq, 4'b1111 & 4'(m));
            chk("R8 irq", irq, m != 0);
        end

        // R5: clear bits 2,3 ignored; level bits still shown
        clr_we = 1; clr_wdata = 4'b1100; step(); clr_we = 0;
        chk("R5 clear levels ignored", raw_irq, 4'b1111);
        clr_we = 1; clr_wdata = 4'b0001; step(); clr_we = 0;
        chk("R5 clear ovr", raw_irq, 4'b1110);
        clr_we = 1; clr_wdata = 4'b0010; step(); clr_we = 0;
        chk("R5 clear rto", raw_irq, 4'b1100);

        // R6: event and clear collide, set wins
        ovr_pulse = 1; clr_we = 1; clr_wdata = 4'b0011; step();
        ovr_pulse = 0; clr_we = 0;
        chk("R6 set wins", raw_irq, 4'b1101);

        // R8: mask only sticky bit, then clear it -> line drops
        mask_we = 1; mask_wdata = 4'b0001; step(); mask_we = 0;
        chk("R8 line on", irq, 1'b1);
        clr_we = 1; clr_wdata = 4'b0001; step(); clr_we = 0;
        chk("R8 line off", irq, 1'b0);
        chk("R7 masked zero", masked_irq, 4'b0000);

        // R2 R3: level bits follow counts; masked follows too
        mask_we = 1; mask_wdata = 4'b1100; step(); mask_we = 0;
        sticky = 4'b0000;
        for (int t = 0; t <= 8; t++) begin
            tx_count = 4'(t); rx_count = 4'(8 - t);
            step();
            raw_e = sticky | {t <= 4, (8 - t) >= 4, 2'b00};
            chk("R3 mixed raw", raw_irq, raw_e);
            chk("R7 mixed masked", masked_irq, raw_e & 4'b1100);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule